// File: doc/BRIEF.md
# Multicore Interrupt Distributor

This block hands external interrupt levels to the cores of a small shared-memory multiprocessor. Each external input passes through a two-flop synchronizer and then fans out to one interrupt line per core. Two pieces of state gate each input. The first is a global enable bit, which software changes only through a set port and a clear port. The second is a per-input core bitmask that names the cores receiving the input. If an input is enabled while its routing mask is empty, the mask is loaded with core 0 so that the input always has a destination.

The block also holds a 16-bit inter-processor cause register for each core. Writing a core bitmask to one of sixteen set addresses raises the matching cause bit in every named core. Each core acknowledges its own bits with a write-one-to-clear access. A core's IPI line is high while any of its cause bits is set.

The remaining registers are a set-only assert register, an 8-bit partition register, a read-only configuration word, a per-core stall mask driven out as pins, and a coherency-enable bit. Software reaches all of them through a word-addressed port with separate read and write strobes. Read data is registered.

Top module: `irq_distributor`

## Requirements
- R1: After reset every enable, routing mask, cause bit, assert bit, partition bit, stall bit and the coherency bit read zero, and every interrupt, IPI and stall output is low.
- R2: The routing register of input n is at address 0x000+n and holds a NUM_CORES-bit core mask. The output bit core_irq_o[c*NUM_IRQ+n] is high exactly when the synchronized input n, enable bit n and routing bit c are all set.
- R3: An input change first appears at core_irq_o after the second rising clock edge following it.
- R4: A write to 0x184 sets the enable bits that are one in the written mask. A write to 0x180 clears them. Zero mask bits leave their enables unchanged. A read of 0x180 returns the enables in bits NUM_IRQ-1:0.
- R5: Setting an enable bit that was clear, while that input's routing mask is zero, loads the routing mask with the value 1 (core 0). A non-zero routing mask is left as it was.
- R6: The cause register of core p is at 0x100+p, reads back its 16 bits, and a write to it clears the bits that are one in bits 15:0 of the data.
- R7: A write of a core mask to 0x140+c (c from 0 to 15) sets cause bit c in every core whose mask bit is set. Other cause bits are unchanged.
- R8: core_ipi_o[p] is high exactly when the cause register of core p is non-zero.
- R9: Address 0x188 reads the assert register, NUM_IRQ bits wide. A write to 0x18C sets the bits that are one in the mask. Bits never clear except at reset, and writes to 0x188 are ignored.
- R10: Address 0x190 is an 8-bit read/write partition register. Its read bits 31:8 are zero.
- R11: Address 0x1A0 reads {VERSION[9:0], NUM_CORES-1 in 4 bits, IDENT[17:0]}, from bit 31 down to bit 0. Writes to it are ignored.
- R12: Address 0x200 holds a NUM_CORES-bit stall mask driven on core_stall_o. Address 0x220 holds one coherency bit in bit 0, driven on coherent_en_o.
- R13: reg_rdata changes one clock edge after a cycle with reg_re high and holds otherwise. Unmapped addresses, write-only addresses (0x140-0x14F, 0x184, 0x18C) and routing addresses at or beyond NUM_IRQ read zero. Writes to unmapped addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_IRQ | Level-sensitive external interrupts, asynchronous |
| reg_addr | input | 10 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| core_irq_o | output | NUM_CORES*NUM_IRQ | Per-core, per-input interrupt lines, bit c*NUM_IRQ+n |
| core_ipi_o | output | NUM_CORES | Combined inter-processor interrupt per core |
| core_stall_o | output | NUM_CORES | Run-stall per core |
| coherent_en_o | output | 1 | Coherency enable |

## Verification
The routing path is swept over every input and all sixteen core masks. Only one input is raised at a time, which tells a wrong input index apart from a wrong core index. The mask value zero exercises the rule that loads core 0. Clearing the enable afterwards shows that the gate, not the routing, removes the output. The IPI path is driven with a different core pattern for each of the sixteen cause numbers. A single wrong bit position therefore shows up in the readback of every cause register and in the IPI pins. Partial-mask acknowledges then separate write-one-to-clear from a plain overwrite.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned ADDR_W  = 10;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CAUSE_W = 16;
  localparam int unsigned PART_W  = 8;

  localparam logic [ADDR_W-1:0] A_ROUTE     = 10'h000;
  localparam logic [ADDR_W-1:0] A_CAUSE     = 10'h100;
  localparam logic [ADDR_W-1:0] A_IPISET    = 10'h140;
  localparam logic [ADDR_W-1:0] A_ENCLR     = 10'h180;
  localparam logic [ADDR_W-1:0] A_ENSET     = 10'h184;
  localparam logic [ADDR_W-1:0] A_ASSERT    = 10'h188;
  localparam logic [ADDR_W-1:0] A_ASSERTSET = 10'h18C;
  localparam logic [ADDR_W-1:0] A_PART      = 10'h190;
  localparam logic [ADDR_W-1:0] A_CFGID     = 10'h1A0;
  localparam logic [ADDR_W-1:0] A_STALL     = 10'h200;
  localparam logic [ADDR_W-1:0] A_COHER     = 10'h220;

  // true when addr lies in [base, base+count)
  function automatic logic win_hit(input logic [ADDR_W-1:0] addr,
                                   input logic [ADDR_W-1:0] base,
                                   input int unsigned count);
    return (32'(addr) >= 32'(base)) && ((32'(addr) - 32'(base)) < count);
  endfunction

  // configuration word: version | cores-1 | identifier
  function automatic logic [REG_W-1:0] cfg_word(input logic [9:0] ver,
                                                input int unsigned cores,
                                                input logic [17:0] ident);
    logic [3:0] c;
    c = 4'(cores - 1);
    return {ver, c, ident};
  endfunction
endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q_o) |-> (q_o == $past(stage1_q)));
endmodule

// File: rtl/irqd_route.sv
module irqd_route #(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned IRQ_IW   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_IRQ-1:0]             irq_lvl_i,
  input  logic                           route_we_i,
  input  logic [IRQ_IW-1:0]              route_idx_i,
  input  logic [NUM_CORES-1:0]           route_wmask_i,
  input  logic                           en_set_we_i,
  input  logic                           en_clr_we_i,
  input  logic [NUM_IRQ-1:0]             en_wmask_i,
  output logic [NUM_IRQ-1:0]             en_o,
  output logic [NUM_IRQ*NUM_CORES-1:0]   route_o,
  output logic [NUM_CORES*NUM_IRQ-1:0]   core_irq_o
);
  logic [NUM_IRQ-1:0]   en_q;
  logic [NUM_CORES-1:0] route_q [NUM_IRQ];
  logic [NUM_IRQ-1:0]   route_hit;
  logic [NUM_IRQ-1:0]   default_load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           en_q <= '0;
    else if (en_clr_we_i) en_q <= en_q & ~en_wmask_i;
    else if (en_set_we_i) en_q <= en_q | en_wmask_i;
  end

  assign en_o = en_q;

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq
    assign route_hit[n]    = route_we_i && (route_idx_i == IRQ_IW'(n));
    assign default_load[n] = en_set_we_i && en_wmask_i[n] && !en_q[n] &&
                             (route_q[n] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               route_q[n] <= '0;
      else if (route_hit[n])    route_q[n] <= route_wmask_i;
      else if (default_load[n]) route_q[n] <= NUM_CORES'(1);
    end

    assign route_o[n*NUM_CORES +: NUM_CORES] = route_q[n];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign core_irq_o[c*NUM_IRQ + n] = irq_lvl_i[n] & en_q[n] & route_q[n][c];
    end

    // R5
    default_core0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      default_load[n] |=> (route_q[n] == NUM_CORES'(1)));
  end

  // R4
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_we_i |=> ((en_o & $past(en_wmask_i)) == '0));
  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we_i && !en_clr_we_i) |=> ((en_o & $past(en_wmask_i)) == $past(en_wmask_i)));
  // R4
  en_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_we_i || en_clr_we_i) |=>
      ((en_o & ~$past(en_wmask_i)) == ($past(en_o) & ~$past(en_wmask_i))));
endmodule

// File: rtl/irqd_ipi.sv
module irqd_ipi import irqd_pkg::*; #(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CORE_IW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int unsigned CAUSE_IW = $clog2(CAUSE_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ack_we_i,
  input  logic [CORE_IW-1:0]            ack_idx_i,
  input  logic [CAUSE_W-1:0]            ack_mask_i,
  input  logic                          set_we_i,
  input  logic [CAUSE_IW-1:0]           set_idx_i,
  input  logic [NUM_CORES-1:0]          set_cores_i,
  output logic [NUM_CORES*CAUSE_W-1:0]  cause_o,
  output logic [NUM_CORES-1:0]          ipi_o
);
  logic [CAUSE_W-1:0]   cause_q [NUM_CORES];
  logic [NUM_CORES-1:0] ack_hit;
  logic [NUM_CORES-1:0] set_hit;

  for (genvar p = 0; p < NUM_CORES; p++) begin : g_core
    assign ack_hit[p] = ack_we_i && (ack_idx_i == CORE_IW'(p));
    assign set_hit[p] = set_we_i && set_cores_i[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cause_q[p] <= '0;
      else if (ack_hit[p]) cause_q[p] <= cause_q[p] & ~ack_mask_i;
      else if (set_hit[p]) cause_q[p] <= cause_q[p] | (CAUSE_W'(1) << set_idx_i);
    end

    assign cause_o[p*CAUSE_W +: CAUSE_W] = cause_q[p];
    assign ipi_o[p] = |cause_q[p];

    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit[p] |=> ((cause_q[p] & $past(ack_mask_i)) == '0));
    // R7
    ipi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hit[p] && !ack_we_i) |=> cause_q[p][$past(set_idx_i)]);
    // R8
    ipi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ipi_o[p]) |-> $past(set_hit[p]));
  end
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor import irqd_pkg::*; #(
  parameter int unsigned NUM_IRQ   = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter logic [9:0]  VERSION   = 10'h023,
  parameter logic [17:0] IDENT     = 18'h2A5C3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_IRQ-1:0]           irq_in,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [REG_W-1:0]             reg_wdata,
  input  logic                         reg_we,
  input  logic                         reg_re,
  output logic [REG_W-1:0]             reg_rdata,
  output logic [NUM_CORES*NUM_IRQ-1:0] core_irq_o,
  output logic [NUM_CORES-1:0]         core_ipi_o,
  output logic [NUM_CORES-1:0]         core_stall_o,
  output logic                         coherent_en_o
);
  localparam int unsigned CORE_IW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
  localparam int unsigned IRQ_IW   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int unsigned CAUSE_IW = $clog2(CAUSE_W);
  localparam logic [REG_W-1:0] CFG_ID = cfg_word(VERSION, NUM_CORES, IDENT);

  // address decode
  logic hit_route, hit_cause, hit_ipiset, hit_enclr, hit_enset;
  logic hit_assert, hit_assertset, hit_part, hit_cfg, hit_stall, hit_coher;
  logic hit_readable;

  assign hit_route     = win_hit(reg_addr, A_ROUTE, NUM_IRQ);
  assign hit_cause     = win_hit(reg_addr, A_CAUSE, NUM_CORES);
  assign hit_ipiset    = win_hit(reg_addr, A_IPISET, CAUSE_W);
  assign hit_enclr     = (reg_addr == A_ENCLR);
  assign hit_enset     = (reg_addr == A_ENSET);
  assign hit_assert    = (reg_addr == A_ASSERT);
  assign hit_assertset = (reg_addr == A_ASSERTSET);
  assign hit_part      = (reg_addr == A_PART);
  assign hit_cfg       = (reg_addr == A_CFGID);
  assign hit_stall     = (reg_addr == A_STALL);
  assign hit_coher     = (reg_addr == A_COHER);
  assign hit_readable  = hit_route | hit_cause | hit_enclr | hit_assert |
                         hit_part | hit_cfg | hit_stall | hit_coher;

  logic [IRQ_IW-1:0]   route_idx;
  logic [CORE_IW-1:0]  core_idx;
  logic [CAUSE_IW-1:0] cause_idx;
  assign route_idx = reg_addr[IRQ_IW-1:0];
  assign core_idx  = reg_addr[CORE_IW-1:0];
  assign cause_idx = reg_addr[CAUSE_IW-1:0];

  // synchronizer
  logic [NUM_IRQ-1:0] irq_sync;
  irqd_sync #(.W(NUM_IRQ)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_in),
    .q_o   (irq_sync)
  );

  // enable and routing
  logic [NUM_IRQ-1:0]           en_vec;
  logic [NUM_IRQ*NUM_CORES-1:0] route_flat;
  irqd_route #(.NUM_IRQ(NUM_IRQ), .NUM_CORES(NUM_CORES)) u_route (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_lvl_i     (irq_sync),
    .route_we_i    (reg_we & hit_route),
    .route_idx_i   (route_idx),
    .route_wmask_i (reg_wdata[NUM_CORES-1:0]),
    .en_set_we_i   (reg_we & hit_enset),
    .en_clr_we_i   (reg_we & hit_enclr),
    .en_wmask_i    (reg_wdata[NUM_IRQ-1:0]),
    .en_o          (en_vec),
    .route_o       (route_flat),
    .core_irq_o    (core_irq_o)
  );

  // inter-processor causes
  logic [NUM_CORES*CAUSE_W-1:0] cause_flat;
  irqd_ipi #(.NUM_CORES(NUM_CORES)) u_ipi (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_we_i    (reg_we & hit_cause),
    .ack_idx_i   (core_idx),
    .ack_mask_i  (reg_wdata[CAUSE_W-1:0]),
    .set_we_i    (reg_we & hit_ipiset),
    .set_idx_i   (cause_idx),
    .set_cores_i (reg_wdata[NUM_CORES-1:0]),
    .cause_o     (cause_flat),
    .ipi_o       (core_ipi_o)
  );

  // miscellaneous registers
  logic [NUM_IRQ-1:0]   assert_q;
  logic [PART_W-1:0]    part_q;
  logic [NUM_CORES-1:0] stall_q;
  logic                 coher_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      assert_q <= '0;
      part_q   <= '0;
      stall_q  <= '0;
      coher_q  <= 1'b0;
    end else if (reg_we) begin
      if (hit_assertset) assert_q <= assert_q | reg_wdata[NUM_IRQ-1:0];
      if (hit_part)      part_q   <= reg_wdata[PART_W-1:0];
      if (hit_stall)     stall_q  <= reg_wdata[NUM_CORES-1:0];
      if (hit_coher)     coher_q  <= reg_wdata[0];
    end
  end

  assign core_stall_o  = stall_q;
  assign coherent_en_o = coher_q;

  // read path
  logic [REG_W-1:0] rd_next;
  logic [REG_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    if (hit_route)       rd_next = REG_W'(route_flat[route_idx*NUM_CORES +: NUM_CORES]);
    else if (hit_cause)  rd_next = REG_W'(cause_flat[core_idx*CAUSE_W +: CAUSE_W]);
    else if (hit_enclr)  rd_next = REG_W'(en_vec);
    else if (hit_assert) rd_next = REG_W'(assert_q);
    else if (hit_part)   rd_next = REG_W'(part_q);
    else if (hit_cfg)    rd_next = CFG_ID;
    else if (hit_stall)  rd_next = REG_W'(stall_q);
    else if (hit_coher)  rd_next = REG_W'(coher_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_re) rdata_q <= rd_next;
  end

  assign reg_rdata = rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  // R13
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_re && !hit_readable) |=> (reg_rdata == '0));
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_re |=> $stable(reg_rdata));
  // R9
  assert_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((assert_q & $past(assert_q)) == $past(assert_q)));
  // R12
  stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && hit_stall) |=> (core_stall_o == $past(reg_wdata[NUM_CORES-1:0])));
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 8;
  localparam int NC = 4;
  localparam logic [9:0]  VER = 10'h023;
  localparam logic [17:0] ID  = 18'h2A5C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [9:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic reg_we = 1'b0;
  logic reg_re = 1'b0;
  logic [31:0] reg_rdata;
  logic [NC*NI-1:0] core_irq_o;
  logic [NC-1:0] core_ipi_o;
  logic [NC-1:0] core_stall_o;
  logic coherent_en_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_distributor #(.NUM_IRQ(NI), .NUM_CORES(NC), .VERSION(VER), .IDENT(ID)) i_irq_distributor (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .core_irq_o(core_irq_o), .core_ipi_o(core_ipi_o), .core_stall_o(core_stall_o),
    .coherent_en_o(coherent_en_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_re = 1'b1;
    @(negedge clk);
    reg_re = 1'b0;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] fan(input int n, input logic [NC-1:0] m);
    logic [31:0] r;
    r = '0;
    for (int c = 0; c < NC; c++) if (m[c]) r[c*NI + n] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] cause_set(input logic [31:0] old, input int c);
    return old | (32'd1 << c);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] en_m;
    logic [31:0] cause_m [NC];
    logic [31:0] as_m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(10'h180, d); chk("R1 enables", d, 0);
    for (int n = 0; n < NI; n++) begin rd(10'(n), d); chk("R1 route", d, 0); end
    for (int p = 0; p < NC; p++) begin rd(10'h100 + 10'(p), d); chk("R1 cause", d, 0); end
    rd(10'h188, d); chk("R1 assert", d, 0);
    rd(10'h190, d); chk("R1 partition", d, 0);
    rd(10'h200, d); chk("R1 stall", d, 0);
    rd(10'h220, d); chk("R1 coherency", d, 0);
    chk("R1 outputs", {coherent_en_o, core_stall_o, core_ipi_o, core_irq_o}, 0);

    // R2 R5 routing sweep, one input at a time
    for (int n = 0; n < NI; n++) begin
      for (int m = 0; m < 16; m++) begin
        logic [NC-1:0] me;
        me = (m == 0) ? NC'(1) : NC'(m);
        wr(10'(n), 32'(m));
        wr(10'h184, 32'd1 << n);
        rd(10'(n), d); chk("R5 route after enable", d, 32'(me));
        irq_in = NI'(1) << n;
        repeat (3) @(negedge clk);
        chk("R2 fan-out", 32'(core_irq_o), fan(n, me));
        wr(10'h180, 32'd1 << n);
        chk("R2 disabled", 32'(core_irq_o), 0);
        irq_in = '0;
        repeat (3) @(negedge clk);
      end
    end

    // R5 non-zero routing kept on enable
    wr(10'd2, 32'h6);
    wr(10'h184, 32'h4);
    rd(10'd2, d); chk("R5 nonzero kept", d, 32'h6);

    // R3 synchronizer latency: all inputs routed to core 1
    for (int n = 0; n < NI; n++) wr(10'(n), 32'h2);
    wr(10'h184, 32'hFF);
    @(negedge clk); irq_in = 8'h81;
    @(negedge clk); chk("R3 one edge", 32'(core_irq_o), 0);
    @(negedge clk); chk("R3 two edges", 32'(core_irq_o), 32'h81 << NI);
    irq_in = '0;
    repeat (3) @(negedge clk);
    chk("R3 release", 32'(core_irq_o), 0);

    // R4 enable set/clear sequence
    en_m = 32'hFF;
    wr(10'h180, 32'hFF); en_m = 0;
    rd(10'h180, d); chk("R4 clear all", d, en_m);
    wr(10'h184, 32'hA5); en_m |= 32'hA5;
    rd(10'h180, d); chk("R4 set", d, en_m);
    wr(10'h180, 32'h21); en_m &= ~32'h21;
    rd(10'h180, d); chk("R4 clear", d, en_m);
    wr(10'h184, 32'h0F); en_m |= 32'h0F;
    rd(10'h180, d); chk("R4 set2", d, en_m);
    wr(10'h184, 32'h0); rd(10'h180, d); chk("R4 zero set", d, en_m);
    wr(10'h180, 32'h0); rd(10'h180, d); chk("R4 zero clear", d, en_m);
    rd(10'h184, d); chk("R13 set port reads zero", d, 0);

    // R7 R8 IPI set sweep
    for (int p = 0; p < NC; p++) cause_m[p] = 0;
    for (int c = 0; c < 16; c++) begin
      logic [NC-1:0] cm;
      cm = NC'((c * 5 + 3) & 15);
      wr(10'h140 + 10'(c), {28'hFFFFFF0, cm});
      for (int p = 0; p < NC; p++) if (cm[p]) cause_m[p] = cause_set(cause_m[p], c);
      for (int p = 0; p < NC; p++) begin
        rd(10'h100 + 10'(p), d); chk("R7 cause", d, cause_m[p]);
        chk("R8 ipi", 32'(core_ipi_o[p]), 32'(cause_m[p] != 0));
      end
    end
    rd(10'h140, d); chk("R13 ipi set reads zero", d, 0);

    // R6 R8 write-one-to-clear
    for (int p = 0; p < NC; p++) begin
      wr(10'h100 + 10'(p), 32'hFFFF5555); cause_m[p] &= ~32'h5555;
      rd(10'h100 + 10'(p), d); chk("R6 partial ack", d, cause_m[p]);
      chk("R8 ipi partial", 32'(core_ipi_o[p]), 32'(cause_m[p] != 0));
      wr(10'h100 + 10'(p), 32'h0000FFFF); cause_m[p] = 0;
      rd(10'h100 + 10'(p), d); chk("R6 full ack", d, 0);
      chk("R8 ipi low", 32'(core_ipi_o[p]), 0);
    end

    // R9 assert register
    as_m = 0;
    wr(10'h18C, 32'h12); as_m |= 32'h12;
    wr(10'h18C, 32'h40); as_m |= 32'h40;
    rd(10'h188, d); chk("R9 assert set", d, as_m);
    wr(10'h188, 32'hFF);
    rd(10'h188, d); chk("R9 assert write ignored", d, as_m);
    wr(10'h18C, 32'h0);
    rd(10'h188, d); chk("R9 assert zero mask", d, as_m);

    // R10 partition
    wr(10'h190, 32'hFFFF_01AB);
    rd(10'h190, d); chk("R10 partition", d, 32'hAB);

    // R11 configuration word
    rd(10'h1A0, d);
    chk("R11 cfg id", d, (32'(VER) << 22) | (32'(NC - 1) << 18) | 32'(ID));
    wr(10'h1A0, 32'h0);
    rd(10'h1A0, d);
    chk("R11 cfg write ignored", d, (32'(VER) << 22) | (32'(NC - 1) << 18) | 32'(ID));

    // R12 stall and coherency
    wr(10'h200, 32'hFFFF_FFF5);
    chk("R12 stall pins", 32'(core_stall_o), 32'h5);
    rd(10'h200, d); chk("R12 stall read", d, 32'h5);
    wr(10'h220, 32'h3);
    chk("R12 coherency pin", 32'(coherent_en_o), 1);
    rd(10'h220, d); chk("R12 coherency read", d, 1);

    // R13 unmapped accesses and read hold
    wr(10'h0F0, 32'hFFFF_FFFF);
    rd(10'h0F0, d); chk("R13 route beyond range", d, 0);
    wr(10'h3FF, 32'hFFFF_FFFF);
    rd(10'h3FF, d); chk("R13 unmapped", d, 0);
    rd(10'h180, d); chk("R13 enables untouched", d, en_m);
    rd(10'h190, d);
    reg_addr = 10'h1A0;
    repeat (3) @(negedge clk);
    chk("R13 hold without strobe", reg_rdata, 32'hAB);

    finish_run();
  end
endmodule